// File: doc/BRIEF.md
# Serial Character Receiver with Sync-Character Hunt

This block is the receive half of a programmable serial port. A slow receive clock (`rxc`) and the serial line (`rxd`) arrive from outside and are synchronized into the system clock domain. The line is sampled on every rising edge of `rxc`. Bits arrive least-significant first and are assembled into 8-bit characters. Each finished character is moved into a one-entry receive buffer. The host takes characters from that buffer through a valid/ready pair.

In synchronous mode the receiver first hunts for alignment. In internal mode it slides an 8-bit window over the incoming bits and compares it with one programmed sync character, or with two in sequence. In external mode, outside logic raises `syndet_in` and the next falling edge of `rxc` fixes the character boundary. In asynchronous mode each bit lasts 1, 16 or 64 receive-clock periods. A start bit is confirmed at its midpoint, and the character is handed over once the stop bit has been sampled.

The receive stream has no stall path, because the serial line cannot be held off. `rx_valid` stays high and `rx_data` stays stable until a cycle with `rx_valid && rx_ready`, or until a newer character overwrites the buffer. In that second case the sticky `overrun` flag is raised.

Top module: `usrx_top`

## Requirements
- R1: Line bits are taken on rising edges of `rxc`. The first bit received becomes bit 0 of the character.
- R2: `mode` encoding: 0 = synchronous, 1 = asynchronous ×1, 2 = asynchronous ×16, 3 = asynchronous ×64 (receive-clock periods per bit). A low level on `rxd` that is gone by the start bit's midpoint sample is dropped as a false start. Each later bit is sampled one bit time after the previous sample. The character is transferred at the stop-bit sample.
- R3: A transfer fills the buffer and shows the character on `rx_data`. A cycle with `rx_valid && rx_ready` empties the buffer, and `rx_valid` is low on the next cycle.
- R4: `rx_valid` is high only while `rx_enable` is high. Characters are still assembled and stored while it is low, and they become visible as soon as it is raised.
- R5: A transfer into a full buffer that is not being read in that same cycle sets `overrun`. The newer character replaces the older one. `overrun` stays set until an `err_clr` pulse or reset.
- R6: In internal sync mode with one sync character, `syndet_out` rises once the last bit of a window equal to `sync_a` has been taken. Characters are then framed from the following bit.
- R7: With `dual_sync` high, `syndet_out` rises only when `sync_b` follows `sync_a` directly. If the character after `sync_a` is not `sync_b`, the hunt for `sync_a` resumes and `syndet_out` stays low.
- R8: `syndet_out` is cleared by a `stat_rd` pulse or by reset, and stays low while characters continue to arrive.
- R9: `syndet_oe` is high only in synchronous mode with `ext_sync` low. In external mode the rising edges seen while hunting are ignored. A `syndet_in` level that is high at a falling edge of `rxc` starts character framing at the next rising edge.
- R10: A `hunt_req` pulse returns the receiver to its hunting state (sync modes) or its idle state (async modes).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxc | input | 1 | Receive clock from the line side |
| rxd | input | 1 | Serial receive data |
| mode | input | 2 | Operating mode, encoding in R2 |
| ext_sync | input | 1 | 1 = external sync alignment in synchronous mode |
| dual_sync | input | 1 | 1 = two sync characters in internal sync mode |
| sync_a | input | 8 | First (or only) sync character |
| sync_b | input | 8 | Second sync character |
| hunt_req | input | 1 | One-cycle pulse: restart hunt / go idle |
| rx_enable | input | 1 | Receiver enable, gates `rx_valid` |
| err_clr | input | 1 | One-cycle pulse: clear `overrun` |
| stat_rd | input | 1 | One-cycle pulse: status read, clears sync detect |
| syndet_in | input | 1 | External sync indication |
| syndet_out | output | 1 | Sync detected (internal mode) |
| syndet_oe | output | 1 | Drive enable for the sync-detect pad |
| rx_valid | output | 1 | Buffer holds an unread character and receiver is enabled |
| rx_ready | input | 1 | Host accepts the character |
| rx_data | output | 8 | Buffered character |
| overrun | output | 1 | Sticky overrun flag |

## Verification
Synchronous framing is driven with a junk-then-sync pattern. This shows the sliding window matches only on exact alignment, and that the data after the sync byte is framed on the right boundary. A sync/wrong/sync/sync sequence in dual mode separates a correct pair match from a match on the first character alone. External mode is first sent a byte with `syndet_in` low, then a byte after a one-period pulse, which shows that only the pulse starts framing. The asynchronous modes receive bytes with asymmetric bit patterns at all three divisors, and a short low glitch shows the midpoint start confirmation at work. Two unread characters in a row, and a byte received while disabled, cover overwrite and gating.

// File: rtl/usrx_pkg.sv
package usrx_pkg;
  typedef enum logic [1:0] {
    MD_SYNC    = 2'd0,
    MD_ASYNC1  = 2'd1,
    MD_ASYNC16 = 2'd2,
    MD_ASYNC64 = 2'd3
  } usrx_mode_e;

  typedef enum logic [2:0] {
    ST_HUNT1,
    ST_HUNT2,
    ST_SDATA,
    ST_AIDLE,
    ST_ASTART,
    ST_ADATA,
    ST_ASTOP
  } usrx_state_e;
endpackage

// File: rtl/usrx_edge.sv
module usrx_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxc,
  input  logic rxd,
  input  logic syndet_in,
  output logic rise,
  output logic fall,
  output logic rxd_s,
  output logic sdin_s
);
  logic [STAGES:0]   rxc_p;
  logic [STAGES-1:0] rxd_p;
  logic [STAGES-1:0] sdi_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxc_p <= '0;
      rxd_p <= '1;
      sdi_p <= '0;
    end else begin
      rxc_p <= {rxc_p[STAGES-1:0], rxc};
      rxd_p <= {rxd_p[STAGES-2:0], rxd};
      sdi_p <= {sdi_p[STAGES-2:0], syndet_in};
    end
  end

  // data and sync input are aligned with the newest synchronized clock level
  assign rise   = rxc_p[STAGES-1] & ~rxc_p[STAGES];
  assign fall   = ~rxc_p[STAGES-1] & rxc_p[STAGES];
  assign rxd_s  = rxd_p[STAGES-1];
  assign sdin_s = sdi_p[STAGES-1];
endmodule

// File: rtl/usrx_framer.sv
module usrx_framer
  import usrx_pkg::*;
#(
  parameter int CHAR_W  = 8,
  parameter int DIV_MED = 16,
  parameter int DIV_HI  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              fall,
  input  logic              rxd_s,
  input  logic              sdin_s,
  input  usrx_mode_e        md,
  input  logic              ext_sync,
  input  logic              dual_sync,
  input  logic [CHAR_W-1:0] sync_a,
  input  logic [CHAR_W-1:0] sync_b,
  input  logic              hunt_req,
  output logic              load,
  output logic [CHAR_W-1:0] load_char,
  output logic              hit
);
  localparam int PH_W = $clog2(DIV_HI);
  localparam int CW_W = $clog2(CHAR_W + 1);
  localparam logic [CW_W-1:0] LAST = CW_W'(CHAR_W - 1);

  usrx_state_e       st;
  logic [CHAR_W-1:0] sh, nxt;
  logic [CW_W-1:0]   cnt;
  logic [PH_W-1:0]   ph;
  logic [PH_W:0]     div, half;
  logic              is_async, in_async, restart, last_bit, ph_end, ph_half;

  always_comb begin
    case (md)
      MD_ASYNC1:  div = (PH_W+1)'(1);
      MD_ASYNC16: div = (PH_W+1)'(DIV_MED);
      default:    div = (PH_W+1)'(DIV_HI);
    endcase
  end

  assign half     = div >> 1;
  assign is_async = (md != MD_SYNC);
  assign in_async = (st == ST_AIDLE) || (st == ST_ASTART) || (st == ST_ADATA) || (st == ST_ASTOP);
  assign restart  = hunt_req || (is_async != in_async);
  assign nxt      = {rxd_s, sh[CHAR_W-1:1]};
  assign last_bit = (cnt == LAST);
  assign ph_end   = ({1'b0, ph} == div - 1'b1);
  assign ph_half  = ({1'b0, ph} == half);

  assign hit = rise && !restart && !ext_sync &&
               ((st == ST_HUNT1 && last_bit && !dual_sync && nxt == sync_a) ||
                (st == ST_HUNT2 && last_bit && nxt == sync_b));
  assign load = rise && !restart &&
                ((st == ST_SDATA && last_bit) || (st == ST_ASTOP && ph_end));
  assign load_char = (st == ST_SDATA) ? nxt : sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_HUNT1;
      sh  <= '0;
      cnt <= '0;
      ph  <= '0;
    end else if (restart) begin
      st  <= is_async ? ST_AIDLE : ST_HUNT1;
      cnt <= '0;
      ph  <= '0;
    end else begin
      case (st)
        ST_HUNT1: begin
          if (ext_sync) begin
            if (fall && sdin_s) begin
              st  <= ST_SDATA;
              cnt <= '0;
            end
          end else if (rise) begin
            sh <= nxt;
            if (last_bit && nxt == sync_a) begin
              st  <= dual_sync ? ST_HUNT2 : ST_SDATA;
              cnt <= '0;
            end else if (!last_bit) begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_HUNT2: if (rise) begin
          sh <= nxt;
          if (last_bit) begin
            // mismatch keeps the window full so the slide continues at once
            st  <= (nxt == sync_b) ? ST_SDATA : ST_HUNT1;
            cnt <= (nxt == sync_b) ? '0 : LAST;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SDATA: if (rise) begin
          sh  <= nxt;
          cnt <= last_bit ? '0 : cnt + 1'b1;
        end
        ST_AIDLE: if (rise && !rxd_s) begin
          if (half == '0) begin
            st  <= ST_ADATA;
            ph  <= '0;
            cnt <= '0;
          end else begin
            st <= ST_ASTART;
            ph <= PH_W'(1);
          end
        end
        ST_ASTART: if (rise) begin
          if (ph_half) begin
            st  <= rxd_s ? ST_AIDLE : ST_ADATA;
            ph  <= '0;
            cnt <= '0;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        ST_ADATA: if (rise) begin
          if (ph_end) begin
            ph <= '0;
            sh <= nxt;
            if (last_bit) st <= ST_ASTOP;
            else          cnt <= cnt + 1'b1;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        ST_ASTOP: if (rise) begin
          if (ph_end) begin
            st <= ST_AIDLE;
            ph <= '0;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        default: st <= ST_HUNT1;
      endcase
    end
  end

  AST_HIT_ONLY_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (md == MD_SYNC && !ext_sync));  // R6
  AST_FRAME_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !dual_sync) |=> (st == ST_SDATA && cnt == '0));  // R6
endmodule

// File: rtl/usrx_rxbuf.sv
module usrx_rxbuf #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CHAR_W-1:0] char_in,
  input  logic              hit,
  input  logic              rx_enable,
  input  logic              rx_ready,
  input  logic              err_clr,
  input  logic              stat_rd,
  output logic              rx_valid,
  output logic [CHAR_W-1:0] rx_data,
  output logic              overrun,
  output logic              syndet
);
  logic full, take;

  assign rx_valid = full && rx_enable;
  assign take     = rx_valid && rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full    <= 1'b0;
      rx_data <= '0;
      overrun <= 1'b0;
      syndet  <= 1'b0;
    end else begin
      if (load) begin
        rx_data <= char_in;
        full    <= 1'b1;
      end else if (take) begin
        full <= 1'b0;
      end
      if (load && full && !take) overrun <= 1'b1;
      else if (err_clr)          overrun <= 1'b0;
      if (hit)          syndet <= 1'b1;
      else if (stat_rd) syndet <= 1'b0;
    end
  end

  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (load && full && !take) |=> overrun);  // R5
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !err_clr) |=> overrun);  // R5
  AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !load) |=> !rx_valid);  // R3
  AST_LOAD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (rx_data == $past(char_in)));  // R3
  AST_SDET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !hit) |=> !syndet);  // R8
endmodule

// File: rtl/usrx_top.sv
module usrx_top
  import usrx_pkg::*;
#(
  parameter int CHAR_W  = 8,
  parameter int DIV_MED = 16,
  parameter int DIV_HI  = 64,
  parameter int STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxc,
  input  logic              rxd,
  input  logic [1:0]        mode,
  input  logic              ext_sync,
  input  logic              dual_sync,
  input  logic [CHAR_W-1:0] sync_a,
  input  logic [CHAR_W-1:0] sync_b,
  input  logic              hunt_req,
  input  logic              rx_enable,
  input  logic              err_clr,
  input  logic              stat_rd,
  input  logic              syndet_in,
  output logic              syndet_out,
  output logic              syndet_oe,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [CHAR_W-1:0] rx_data,
  output logic              overrun
);
  usrx_mode_e        md;
  logic              rise, fall, rxd_s, sdin_s, load, hit;
  logic [CHAR_W-1:0] load_char;

  assign md        = usrx_mode_e'(mode);
  assign syndet_oe = (md == MD_SYNC) && !ext_sync;

  usrx_edge #(.STAGES(STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .rxc(rxc), .rxd(rxd), .syndet_in(syndet_in),
    .rise(rise), .fall(fall), .rxd_s(rxd_s), .sdin_s(sdin_s)
  );

  usrx_framer #(.CHAR_W(CHAR_W), .DIV_MED(DIV_MED), .DIV_HI(DIV_HI)) u_framer (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .rxd_s(rxd_s),
    .sdin_s(sdin_s), .md(md), .ext_sync(ext_sync), .dual_sync(dual_sync),
    .sync_a(sync_a), .sync_b(sync_b), .hunt_req(hunt_req),
    .load(load), .load_char(load_char), .hit(hit)
  );

  usrx_rxbuf #(.CHAR_W(CHAR_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .load(load), .char_in(load_char), .hit(hit),
    .rx_enable(rx_enable), .rx_ready(rx_ready), .err_clr(err_clr),
    .stat_rd(stat_rd), .rx_valid(rx_valid), .rx_data(rx_data),
    .overrun(overrun), .syndet(syndet_out)
  );

  AST_OE_EXT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sync || md != MD_SYNC) |-> !syndet_oe);  // R9
endmodule

// File: tb/tb_usrx_top.sv
module tb_usrx_top;
  logic       clk = 1'b0;
  logic       rst_n, rxc, rxd, ext_sync, dual_sync, hunt_req, rx_enable;
  logic       err_clr, stat_rd, syndet_in, rx_ready;
  logic [1:0] mode;
  logic [7:0] sync_a, sync_b, rx_data;
  logic       syndet_out, syndet_oe, rx_valid, overrun;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  usrx_top dut (
    .clk(clk), .rst_n(rst_n), .rxc(rxc), .rxd(rxd), .mode(mode),
    .ext_sync(ext_sync), .dual_sync(dual_sync), .sync_a(sync_a), .sync_b(sync_b),
    .hunt_req(hunt_req), .rx_enable(rx_enable), .err_clr(err_clr),
    .stat_rd(stat_rd), .syndet_in(syndet_in), .syndet_out(syndet_out),
    .syndet_oe(syndet_oe), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .overrun(overrun)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rxc_cycle();
    rxc = 1'b1; tick(4);
    rxc = 1'b0; tick(4);
  endtask

  task automatic send_sync(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      rxc_cycle();
    end
  endtask

  task automatic send_async(input logic [7:0] b, input int div);
    rxd = 1'b0; repeat (div) rxc_cycle();
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (div) rxc_cycle();
    end
    rxd = 1'b1; repeat (3 * div) rxc_cycle();
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; tick(1); s = 1'b0; tick(1);
  endtask

  task automatic t_reset();
    check("R3 reset valid", rx_valid, 0);
    check("R5 reset overrun", overrun, 0);
    check("R8 reset syndet", syndet_out, 0);
    check("R9 oe internal sync", syndet_oe, 1);
  endtask

  task automatic t_single();
    send_sync(8'hFF);
    check("R6 no sync on junk", syndet_out, 0);
    send_sync(8'h16);
    check("R6 sync found", syndet_out, 1);
    check("R6 sync not stored", rx_valid, 0);
    send_sync(8'hA5);
    check("R1 char valid", rx_valid, 1);
    check("R1 lsb-first data", rx_data, 8'hA5);
    pulse(rx_ready);
    check("R3 read empties", rx_valid, 0);
  endtask

  task automatic t_status();
    pulse(stat_rd);
    check("R8 status read clears", syndet_out, 0);
    send_sync(8'h16);
    check("R8 stays low in data", syndet_out, 0);
    check("R6 aligned data", rx_data, 8'h16);
    pulse(rx_ready);
  endtask

  task automatic t_overrun();
    send_sync(8'h11);
    send_sync(8'h22);
    check("R5 overrun set", overrun, 1);
    check("R5 newer kept", rx_data, 8'h22);
    send_sync(8'h33);
    check("R5 overrun sticky", overrun, 1);
    pulse(err_clr);
    check("R5 err_clr clears", overrun, 0);
    check("R5 still valid", rx_valid, 1);
    pulse(rx_ready);
    check("R3 empty after read", rx_valid, 0);
  endtask

  task automatic t_enable();
    rx_enable = 1'b0;
    send_sync(8'h4B);
    check("R4 gated valid", rx_valid, 0);
    rx_enable = 1'b1; tick(1);
    check("R4 visible on enable", rx_valid, 1);
    check("R4 data kept", rx_data, 8'h4B);
    pulse(rx_ready);
  endtask

  task automatic t_dual();
    dual_sync = 1'b1;
    pulse(hunt_req);
    send_sync(8'h16);
    check("R7 first char alone", syndet_out, 0);
    send_sync(8'h00);
    check("R7 wrong second", syndet_out, 0);
    send_sync(8'h16);
    send_sync(8'h2C);
    check("R7 pair found", syndet_out, 1);
    check("R10 no chars while hunting", rx_valid, 0);
    send_sync(8'h69);
    check("R7 data after pair", rx_data, 8'h69);
    pulse(rx_ready);
    pulse(stat_rd);
    dual_sync = 1'b0;
  endtask

  task automatic t_ext();
    ext_sync = 1'b1; tick(1);
    check("R9 oe off external", syndet_oe, 0);
    pulse(hunt_req);
    send_sync(8'h77);
    check("R9 rises ignored in hunt", rx_valid, 0);
    rxd = 1'b1;
    syndet_in = 1'b1;
    rxc_cycle();
    syndet_in = 1'b0;
    send_sync(8'h5A);
    check("R9 external framing valid", rx_valid, 1);
    check("R9 external framing data", rx_data, 8'h5A);
    check("R9 no internal detect", syndet_out, 0);
    pulse(rx_ready);
    ext_sync = 1'b0;
  endtask

  task automatic t_async();
    mode = 2'd2; rxd = 1'b1; tick(1);
    check("R9 oe off async", syndet_oe, 0);
    rxd = 1'b0; repeat (4) rxc_cycle();
    rxd = 1'b1; repeat (24) rxc_cycle();
    check("R2 false start dropped", rx_valid, 0);
    send_async(8'hC3, 16);
    check("R2 x16 valid", rx_valid, 1);
    check("R2 x16 data", rx_data, 8'hC3);
    pulse(rx_ready);
    mode = 2'd3; tick(2);
    send_async(8'h81, 64);
    check("R2 x64 data", rx_data, 8'h81);
    check("R2 x64 single char", overrun, 0);
    pulse(rx_ready);
    mode = 2'd1; tick(2);
    send_async(8'h7E, 1);
    check("R2 x1 valid", rx_valid, 1);
    check("R2 x1 data", rx_data, 8'h7E);
    pulse(rx_ready);
  endtask

  initial begin
    rst_n = 1'b0; rxc = 1'b0; rxd = 1'b1; mode = 2'd0; ext_sync = 1'b0;
    dual_sync = 1'b0; sync_a = 8'h16; sync_b = 8'h2C; hunt_req = 1'b0;
    rx_enable = 1'b1; err_clr = 1'b0; stat_rd = 1'b0; syndet_in = 1'b0;
    rx_ready = 1'b0;
    tick(5); rst_n = 1'b1; tick(3);
    t_reset();
    t_single();
    t_status();
    t_overrun();
    t_enable();
    t_dual();
    t_ext();
    t_async();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule